// File: doc/BRIEF.md
# Vector Predicate Compare Unit

This block compares two operand vectors element by element and builds a predicate bit mask, one bit per element. A start pulse hands it a 16-bit compressed predicate-compare instruction word, both operand vectors of 32-bit elements, and an active length. It then walks the active elements, one per cycle, and pulses `done` when the mask is complete.

Four instruction bits select the comparison and one bit selects signed-integer or single-precision floating-point ordering. There are only four comparators: equal, not-equal, less-than and less-or-equal. Greater-than and greater-or-equal reuse less-than and less-or-equal with the two operands swapped. The block also captures the destination predicate register index from the instruction and presents it beside the mask. The predicate register file belongs to the consumer.

Top module: `pred_cmp_unit`

## Requirements
- R1: The comparison code is {insn[15], insn[14], insn[13], insn[5]}. Code 0 is equal, 1 is not-equal, 2 is less-than, 3 is less-or-equal, 4 is greater-than and 5 is greater-or-equal. Each element compares src1 against src2.
- R2: When insn[6] is 0, elements are compared as signed 32-bit two's-complement integers.
- R3: When insn[6] is 1, elements are compared as single-precision floating-point values, negative values included.
- R4: In floating-point mode, a compare with a NaN on either side gives 0 for every code except not-equal, which gives 1.
- R5: In floating-point mode, +0 (0x00000000) and -0 (0x80000000) compare equal.
- R6: Greater-than gives the same result as less-than with src1 and src2 swapped. Greater-or-equal gives the same result as less-or-equal with the operands swapped.
- R7: Mask bit i holds the result for element i, taken from bits [32*i+31:32*i] of each operand vector. Bits at index vlen and above are 0. A vlen above NUM_ELEM is treated as NUM_ELEM.
- R8: The block compares one element per cycle. `done` is high for exactly one cycle, max(vlen,1) cycles after the clock edge that accepts `start`, and `busy` is low from that cycle on.
- R9: Codes 6 to 15 set `illegal` and give an all-zero mask. `done` still pulses after one cycle.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: `pred_dst` shows insn[11:7] of the accepted instruction and holds it until the next accepted start.
- R12: After reset, `busy`, `done`, `illegal` and `mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts an operation when the block is idle |
| insn | input | 16 | Compressed predicate-compare instruction word |
| src1 | input | NUM_ELEM*32 | First operand vector, element i at bits [32*i+31:32*i] |
| src2 | input | NUM_ELEM*32 | Second operand vector, same layout as src1 |
| vlen | input | VLW | Active element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the mask is final |
| mask | output | NUM_ELEM | Predicate mask, bit i for element i |
| illegal | output | 1 | Last accepted instruction had an unused comparison code |
| pred_dst | output | 5 | Destination predicate register index |

## Verification
The bench builds the block with its defaults, NUM_ELEM=8 and VLW=4. This lets vlen go from 0 up to 15, so one run reaches the empty vector, every partial length, the full length and the clamping of lengths above eight. With eight elements per run, a single vector mixes NaNs, signed zeros, infinities and random values against random codes in both modes. The latency check covers every length up to the full vector.

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
  parameter int NUM_ELEM = 8,
  parameter int VLW = $clog2(NUM_ELEM + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [15:0]              insn,
  input  logic [NUM_ELEM*32-1:0]   src1,
  input  logic [NUM_ELEM*32-1:0]   src2,
  input  logic [VLW-1:0]           vlen,
  output logic                     busy,
  output logic                     done,
  output logic [NUM_ELEM-1:0]      mask,
  output logic                     illegal,
  output logic [4:0]               pred_dst
);
  localparam int IW = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic [3:0]             op_q;
  logic                   fp_q;
  logic [NUM_ELEM*32-1:0] a_q, b_q;
  logic [VLW-1:0]         vl_q;
  logic [IW-1:0]          idx;

  wire [3:0]  code   = {insn[15], insn[14], insn[13], insn[5]};
  wire [31:0] ea     = a_q[idx*32 +: 32];
  wire [31:0] eb     = b_q[idx*32 +: 32];
  wire        swap   = (op_q == 4'd4) || (op_q == 4'd5);
  wire [31:0] x      = swap ? eb : ea;
  wire [31:0] y      = swap ? ea : eb;

  wire x_nan   = (&x[30:23]) && (|x[22:0]);
  wire y_nan   = (&y[30:23]) && (|y[22:0]);
  wire any_nan = x_nan || y_nan;
  wire zeros   = ~|x[30:0] && ~|y[30:0];

  wire mag_lt  = x[30:0] < y[30:0];
  wire mag_gt  = x[30:0] > y[30:0];
  wire f_lt    = !any_nan && !zeros &&
                 ((x[31] && !y[31]) || (!x[31] && !y[31] && mag_lt) ||
                  (x[31] && y[31] && mag_gt));
  wire f_eq    = !any_nan && ((x == y) || zeros);
  wire i_lt    = $signed(x) < $signed(y);
  wire i_eq    = x == y;

  wire lt = fp_q ? f_lt : i_lt;
  wire eq = fp_q ? f_eq : i_eq;

  logic res;
  always_comb begin
    case (op_q)
      4'd0:       res = eq;
      4'd1:       res = !eq;
      4'd2, 4'd4: res = lt;
      4'd3, 4'd5: res = lt || eq;
      default:    res = 1'b0;
    endcase
  end

  wire last = (VLW'(idx) == vl_q - VLW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      mask     <= '0;
      illegal  <= 1'b0;
      pred_dst <= '0;
      op_q     <= '0;
      fp_q     <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      vl_q     <= '0;
      idx      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          mask     <= '0;
          idx      <= '0;
          op_q     <= code;
          fp_q     <= insn[6];
          illegal  <= code > 4'd5;
          pred_dst <= insn[11:7];
          a_q      <= src1;
          b_q      <= src2;
          vl_q     <= (vlen > VLW'(NUM_ELEM)) ? VLW'(NUM_ELEM) : vlen;
        end
      end else if (illegal || vl_q == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        mask[idx] <= res;
        idx       <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pred_cmp_unit_chk.sv
module pred_cmp_unit_chk #(
  parameter int NUM_ELEM = 8,
  parameter int VLW = $clog2(NUM_ELEM + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [VLW-1:0]      vlen,
  input logic                busy,
  input logic                done,
  input logic [NUM_ELEM-1:0] mask,
  input logic                illegal,
  input logic [4:0]          pred_dst
);
  logic [VLW-1:0]      vl_c;
  logic [NUM_ELEM-1:0] keep;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vl_c <= '0;
    else if (start && !busy) vl_c <= vlen;

  always_comb
    for (int i = 0; i < NUM_ELEM; i++) keep[i] = (i < int'(vl_c));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (mask == '0));
  p_tail_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((mask & ~keep) == '0));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(pred_dst));
endmodule

bind pred_cmp_unit pred_cmp_unit_chk #(.NUM_ELEM(NUM_ELEM), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .busy(busy),
  .done(done), .mask(mask), .illegal(illegal), .pred_dst(pred_dst));

// File: tb/pred_cmp_unit_test.sv
module pred_cmp_unit_test;
  localparam int N = 8;
  localparam int VLW = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] insn = '0;
  logic [N*32-1:0] src1 = '0, src2 = '0;
  logic [VLW-1:0] vlen = '0;
  logic busy, done, illegal;
  logic [N-1:0] mask;
  logic [4:0] pred_dst;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pred_cmp_unit #(.NUM_ELEM(N), .VLW(VLW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .src1(src1),
    .src2(src2), .vlen(vlen), .busy(busy), .done(done), .mask(mask),
    .illegal(illegal), .pred_dst(pred_dst));

  function automatic logic [15:0] mk_insn(input int code, input bit fp, input int dst);
    logic [15:0] w = 16'($urandom);
    w[15] = code[3]; w[14] = code[2]; w[13] = code[1]; w[5] = code[0];
    w[6] = fp; w[11:7] = dst[4:0];
    return w;
  endfunction

  function automatic bit is_nan(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction

  function automatic logic [32:0] fkey(input logic [31:0] v);
    if (v[30:0] == 0) return 33'h1_0000_0000;
    return v[31] ? {1'b0, ~v} : {1'b1, v};
  endfunction

  function automatic bit ref_cmp(input int code, input bit fp, input logic [31:0] a, input logic [31:0] b);
    bit lt, gt, eq, nan;
    nan = fp && (is_nan(a) || is_nan(b));
    if (fp) begin
      lt = fkey(a) < fkey(b); gt = fkey(a) > fkey(b); eq = fkey(a) == fkey(b);
    end else begin
      lt = $signed(a) < $signed(b); gt = $signed(a) > $signed(b); eq = a == b;
    end
    if (nan) return code == 1;
    case (code)
      0: return eq;
      1: return !eq;
      2: return lt;
      3: return lt || eq;
      4: return gt;
      5: return gt || eq;
      default: return 0;
    endcase
  endfunction

  function automatic logic [N-1:0] ref_mask(input int code, input bit fp, input int vl);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++)
      if (i < vl) m[i] = ref_cmp(code, fp, src1[i*32 +: 32], src2[i*32 +: 32]);
    return m;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] sp[10] = '{32'h0, 32'h80000000, 32'h7FC00000, 32'hFFC00001,
      32'h7F800000, 32'hFF800000, 32'h3F800000, 32'hBF800000, 32'h7F800001, 32'h00000001};
    if ($urandom_range(1) == 0) return sp[$urandom_range(9)];
    return $urandom;
  endfunction

  task automatic run(input string req, input int code, input bit fp, input int vl, input bit poke);
    int dst = $urandom_range(31);
    int eff = vl > N ? N : vl;
    int cyc = 0;
    logic [N-1:0] exp_m;
    @(negedge clk);
    insn = mk_insn(code, fp, dst); vlen = VLW'(vl); start = 1;
    exp_m = (code > 5) ? '0 : ref_mask(code, fp, eff);
    @(negedge clk);
    start = 0;
    if (poke && !done) begin
      insn = mk_insn(1, !fp, dst ^ 5'h1F); src1 = ~src1; vlen = '1; start = 1;
    end
    while (!done && cyc < 50) begin @(negedge clk); start = 0; cyc++; end
    start = 0;
    chk(req, "mask", mask, exp_m);
    chk("R8", "latency", cyc, eff < 1 || code > 5 ? 1 : eff);
    chk("R9", "illegal", illegal, code > 5);
    chk("R11", "pred_dst", pred_dst, dst);
    @(negedge clk);
    chk("R8", "done_pulse", {busy, done}, 0);
  endtask

  task automatic fill();
    for (int i = 0; i < N; i++) begin
      src1[i*32 +: 32] = pick();
      src2[i*32 +: 32] = ($urandom_range(3) == 0) ? src1[i*32 +: 32] : pick();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk("R12", "reset", {busy, done, illegal, mask}, 0);
    rst_n = 1;

    for (int c = 0; c < 6; c++) begin
      src1 = {32'd5, 32'hFFFFFFFF, 32'd7, 32'h80000000, 32'd3, 32'd3, 32'd0, 32'h7FFFFFFF};
      src2 = {32'd5, 32'd1, 32'hFFFFFFF0, 32'd0, 32'd4, 32'd2, 32'd0, 32'h80000000};
      run("R1", c, 0, N, 0);
      run("R2", c, 0, N, 0);
    end
    for (int c = 0; c < 6; c++) begin
      src1 = {32'hBF800000, 32'hC0000000, 32'h3F800000, 32'hFF800000, 32'h7F800000, 32'hBF800000, 32'h40000000, 32'h00000001};
      src2 = {32'hBF800000, 32'hBF800000, 32'hBF800000, 32'h3F800000, 32'h7F7FFFFF, 32'hC0000000, 32'h40000000, 32'h80000000};
      run("R3", c, 1, N, 0);
    end
    for (int c = 0; c < 6; c++) begin
      src1 = {32'h7FC00000, 32'h3F800000, 32'hFF800001, 32'h0, 32'h7FC00000, 32'h1, 32'hFFFFFFFF, 32'h7F800001};
      src2 = {32'h7FC00000, 32'h7FC00001, 32'h0, 32'hFFC00000, 32'h3F800000, 32'h7FFFFFFF, 32'h0, 32'h7F800001};
      run("R4", c, 1, N, 0);
      src1 = {4{32'h00000000, 32'h80000000}};
      src2 = {4{32'h80000000, 32'h00000000}};
      run("R5", c, 1, N, 0);
    end
    fill();
    for (int c = 2; c < 4; c++)
      for (int f = 0; f < 2; f++) begin
        run("R6", c + 2, f[0], N, 0);
        src1 ^= src2; src2 ^= src1; src1 ^= src2;
        run("R6", c, f[0], N, 0);
      end
    for (int v = 0; v < 16; v++) begin fill(); run("R7", $urandom_range(5), $urandom_range(1), v, 0); end
    for (int c = 6; c < 16; c++) begin fill(); run("R9", c, $urandom_range(1), $urandom_range(1, N), 0); end
    fill(); run("R10", 2, 0, 5, 1);
    fill(); run("R10", 3, 1, N, 1);
    for (int k = 0; k < 60; k++) begin
      int c = $urandom_range(7);
      bit f = $urandom_range(1);
      fill();
      run(c > 5 ? "R9" : (f ? "R3" : "R2"), c, f, $urandom_range(N + 2), 0);
    end
    finished = 1;
  end

  initial begin
    int t = 0;
    while (!finished && t < 100000) begin @(posedge clk); t++; end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", t);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule